// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is a single-master I2C transmitter that software drives through three byte-wide registers: control, status and data. Software first reads the bus-busy bit to see that the bus is free. It then sets the master and transmit mode bits and requests a start by writing the busy bit as 1 with the stop-control bit as 0. The block pulls SDA low while SCL is high and raises both the start flag and the frame flag.

Each byte written to the data register goes out MSB first as eight SCL pulses, followed by a ninth pulse on which the slave's acknowledge is sampled. The frame flag rises at the start of that ninth high phase. SCL is then parked low until software writes the next byte. A stop is requested by writing both the busy bit and the stop-control bit as 0 while SCL is parked. The stop sequence takes SDA low, releases SCL and then releases SDA.

Both bus lines are open-drain: the block only drives enable-low signals. The incoming line levels pass through a two-flop synchronizer. Every SCL phase lasts at least `PHASE_CLKS` system clocks, and a high phase is only counted once the line is seen high.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line drivers are off, `irq` is 0, and the control (address 0), status (address 1) and data (address 2) registers all read 0.
- R2: A control write with bit 2 (busy) = 1, bit 0 (stop-control) = 0, bit 6 (master) = 1 and bit 5 (transmit) = 1 while the bus is free pulls SDA low while SCL stays released. It then sets status bit 7 (frame flag) and status bit 6 (start flag), and control bit 2 reads 1.
- R3: The same start write is ignored when either the master bit or the transmit bit is 0: no SDA fall occurs and control bit 2 stays 0.
- R4: A byte written to the data register while the bus is held appears MSB first, one bit per SCL rising edge. SDA does not change while SCL is high inside a frame.
- R5: Each SCL low or high phase lasts at least `PHASE_CLKS` system clocks.
- R6: On the ninth pulse the SDA level is captured into status bit 0: 0 means acknowledged and 1 means not acknowledged.
- R7: The frame flag is set when SCL is released for the ninth pulse of a frame. `irq` equals the frame flag ANDed with control bit 7 (interrupt enable).
- R8: After the ninth pulse SCL is held low, with no further edges, until the data register is written.
- R9: Writing 0 to status bit 7 or bit 6 clears that flag. Writing 1 leaves it as it is.
- R10: A control write with bit 4 (acknowledge enable) = 0 clears status bit 0.
- R11: A control write with bit 2 = 0 and bit 0 = 0 while SCL is parked produces a stop: SDA rises while SCL is high, both lines end released, and control bit 2 reads 0.
- R12: A data-register write while the bus is free causes no SCL activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |

## Verification
The assertions assume that no other device drives SCL low, apart from stretching a high phase, and that any slave changes SDA only while SCL is low. Without these conditions the phase-length and SDA-stability properties would not hold. The bench models a slave that pulls SDA only in the low phase before the ninth pulse and releases it at the next falling edge. It never drives SCL, so stimulus stays within these assumptions. Register writes come from a single sequential thread, which also keeps the start and stop commands inside the states where they apply.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int FRAME_BITS = 8;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;

    localparam int CB_IRQEN = 7;
    localparam int CB_MST   = 6;
    localparam int CB_TX    = 5;
    localparam int CB_ACKEN = 4;
    localparam int CB_BUSY  = 2;
    localparam int CB_STOP  = 0;

    localparam int SB_FRAME = 7;
    localparam int SB_START = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STA_H,
        ST_STA_L,
        ST_PARK,
        ST_BIT_L,
        ST_BIT_H,
        ST_STO_L,
        ST_STO_H,
        ST_STO_R
    } eng_state_t;

    typedef struct packed {
        logic irq_en;
        logic master;
        logic tx;
        logic ack_en;
        logic rsv3;
        logic busy;
        logic rsv1;
        logic stop;
    } ctrl_view_t;

    typedef struct packed {
        logic       frame;
        logic       start;
        logic [4:0] rsv;
        logic       ack;
    } stat_view_t;

    function automatic logic waits_for_high(eng_state_t s);
        return (s == ST_STA_H) || (s == ST_BIT_H) || (s == ST_STO_H);
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '1;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '1;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
    import i2ct_pkg::*;
#(
    parameter int PHASE_CLKS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_req,
    input  logic                  stop_req,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] tx_byte,
    input  logic                  scl_s,
    output logic                  scl_oe,
    output logic                  sda_oe,
    output logic                  bus_busy,
    output logic                  parked,
    output logic                  take,
    output logic                  evt_start,
    output logic                  evt_frame
);
    localparam int CW = $clog2(PHASE_CLKS + 1);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CLKS - 1);
    localparam logic [BW-1:0] ACK_SLOT = BW'(FRAME_BITS);

    eng_state_t            state, nxt;
    logic [CW-1:0]         cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [BW-1:0]         bidx;
    logic                  hold_off;
    logic                  phase_end;

    assign hold_off  = waits_for_high(state) && !scl_s;
    assign phase_end = !hold_off && (cnt == CNT_LAST);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start_req) nxt = ST_STA_H;
            ST_STA_H: if (phase_end) nxt = ST_STA_L;
            ST_STA_L: if (phase_end) nxt = ST_PARK;
            ST_PARK: begin
                if (stop_req)  nxt = ST_STO_L;
                else if (load) nxt = ST_BIT_L;
            end
            ST_BIT_L: if (phase_end) nxt = ST_BIT_H;
            ST_BIT_H: if (phase_end) nxt = (bidx == ACK_SLOT) ? ST_PARK : ST_BIT_L;
            ST_STO_L: if (phase_end) nxt = ST_STO_H;
            ST_STO_H: if (phase_end) nxt = ST_STO_R;
            ST_STO_R: if (phase_end) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)               cnt <= '0;
            else if (!hold_off && !phase_end) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            bidx  <= '0;
        end else if (state == ST_PARK && nxt == ST_BIT_L) begin
            shreg <= tx_byte;
            bidx  <= '0;
        end else if (state == ST_BIT_H && nxt == ST_BIT_L) begin
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            bidx  <= bidx + 1'b1;
        end
    end

    always_comb begin
        scl_oe = (state == ST_STA_L) || (state == ST_PARK) ||
                 (state == ST_BIT_L) || (state == ST_STO_L);
        case (state)
            ST_STA_H, ST_STA_L, ST_STO_L, ST_STO_H: sda_oe = 1'b1;
            ST_BIT_L, ST_BIT_H: sda_oe = (bidx != ACK_SLOT) && !shreg[FRAME_BITS-1];
            default: sda_oe = 1'b0;
        endcase
    end

    assign bus_busy  = (state != ST_IDLE);
    assign parked    = (state == ST_PARK);
    assign take      = parked && !stop_req && load;
    assign evt_start = (state == ST_IDLE) && start_req;
    assign evt_frame = (state == ST_BIT_L) && phase_end && (bidx == ACK_SLOT);

    // run length of the current SCL drive level, saturating
    logic [CW-1:0] run;
    logic          scl_prev;
    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= '0;
            scl_prev <= 1'b0;
        end else begin
            scl_prev <= scl_oe;
            if (scl_oe != scl_prev)           run <= CW'(1);
            else if (run != CW'(PHASE_CLKS))  run <= run + 1'b1;
        end
    end

    a_r5_phase_len: assert property (@(posedge clk) disable iff (rst)
        (scl_oe != $past(scl_oe)) |-> (run >= CW'(PHASE_CLKS)));

    a_r4_sda_still_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT_H && $past(state) == ST_BIT_H) |-> $stable(sda_oe));

    a_r8_park_low: assert property (@(posedge clk) disable iff (rst)
        (parked && !load) |=> scl_oe);

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2ct_pkg::*;
#(
    parameter int PHASE_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s;

    i2ct_sync #(.WIDTH(2), .STAGES(2)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    logic wr_ctrl, wr_stat, wr_data;
    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign wr_data = reg_wr && (reg_addr == RA_DATA);

    logic irq_en, master_sel, tx_sel, ack_en, stop_ctl;
    logic frame_flag, start_flag, ack_bit;
    logic [FRAME_BITS-1:0] data_reg;
    logic tx_pend;

    logic bus_busy, parked, take, evt_start, evt_frame;
    logic start_req, stop_req;

    assign start_req = wr_ctrl && reg_wdata[CB_BUSY] && !reg_wdata[CB_STOP] &&
                       reg_wdata[CB_MST] && reg_wdata[CB_TX] && !bus_busy;
    assign stop_req  = wr_ctrl && !reg_wdata[CB_BUSY] && !reg_wdata[CB_STOP] && parked;

    i2ct_engine #(.PHASE_CLKS(PHASE_CLKS)) i_engine (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .stop_req  (stop_req),
        .load      (tx_pend),
        .tx_byte   (data_reg),
        .scl_s     (scl_s),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .bus_busy  (bus_busy),
        .parked    (parked),
        .take      (take),
        .evt_start (evt_start),
        .evt_frame (evt_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en     <= 1'b0;
            master_sel <= 1'b0;
            tx_sel     <= 1'b0;
            ack_en     <= 1'b0;
            stop_ctl   <= 1'b0;
        end else if (wr_ctrl) begin
            irq_en     <= reg_wdata[CB_IRQEN];
            master_sel <= reg_wdata[CB_MST];
            tx_sel     <= reg_wdata[CB_TX];
            ack_en     <= reg_wdata[CB_ACKEN];
            stop_ctl   <= reg_wdata[CB_STOP];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_flag <= 1'b0;
            start_flag <= 1'b0;
        end else begin
            if (evt_frame || evt_start)  frame_flag <= 1'b1;
            else if (wr_stat)            frame_flag <= frame_flag && reg_wdata[SB_FRAME];
            if (evt_start)               start_flag <= 1'b1;
            else if (wr_stat)            start_flag <= start_flag && reg_wdata[SB_START];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                 ack_bit <= 1'b0;
        else if (wr_ctrl && !reg_wdata[CB_ACKEN]) ack_bit <= 1'b0;
        else if (evt_frame)                      ack_bit <= sda_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_reg <= '0;
            tx_pend  <= 1'b0;
        end else begin
            if (wr_data) data_reg <= reg_wdata;
            if (wr_data && bus_busy)  tx_pend <= 1'b1;
            else if (take || stop_req) tx_pend <= 1'b0;
        end
    end

    ctrl_view_t cview;
    stat_view_t sview;
    always_comb begin
        cview        = '0;
        cview.irq_en = irq_en;
        cview.master = master_sel;
        cview.tx     = tx_sel;
        cview.ack_en = ack_en;
        cview.busy   = bus_busy;
        cview.stop   = stop_ctl;
        sview        = '0;
        sview.frame  = frame_flag;
        sview.start  = start_flag;
        sview.ack    = ack_bit;
        case (reg_addr)
            RA_CTRL: reg_rdata = cview;
            RA_STAT: reg_rdata = sview;
            RA_DATA: reg_rdata = data_reg;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = frame_flag && irq_en;

    a_r2_start_shape: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> (!scl_oe && sda_oe && start_flag));

    a_r3_mode_gate: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && reg_wdata[CB_BUSY] && !reg_wdata[CB_STOP] &&
         !(reg_wdata[CB_MST] && reg_wdata[CB_TX]) && !bus_busy) |=> !bus_busy);

    a_r7_flag_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_flag) |-> !scl_oe);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !reg_wdata[SB_FRAME] && !evt_frame && !evt_start) |=> !frame_flag);

    a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> (!scl_oe && !sda_oe));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !bus_busy && !start_req) |=> !scl_oe);

endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
    localparam int CLK_PERIOD = 10;
    localparam int PH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       pull = 1'b0;
    wire        scl_line = ~scl_oe;
    wire        sda_line = ~(sda_oe | pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_byte_master #(.PHASE_CLKS(PH)) i_i2c_byte_master (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus monitor and slave acknowledge model
    logic       pscl = 1'b1, psda = 1'b1;
    int         mcnt = 0, frames = 0, starts = 0, stops = 0, falls = 0;
    int         run = 0, min_run = 100000;
    logic [7:0] msh = 8'd0, mbyte = 8'd0;
    bit         ack_mode = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (pscl && scl_line && psda && !sda_line) begin
                starts++; mcnt = 0;
            end else if (pscl && scl_line && !psda && sda_line) begin
                stops++; mcnt = 0;
            end
            if (!pscl && scl_line) begin
                if (mcnt < 8) msh = {msh[6:0], sda_line};
                mcnt++;
            end
            if (pscl && !scl_line) begin
                falls++;
                if (mcnt == 8) pull = ~ack_mode;
                else if (mcnt == 9) begin
                    pull = 1'b0; mcnt = 0; mbyte = msh; frames++;
                end
            end
            if (scl_line != pscl) begin
                if (run < min_run) min_run = run;
                run = 1;
            end else run++;
        end
        pscl = scl_line;
        psda = sda_line;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic poll(input logic [1:0] a, input logic [7:0] mask, input bit want,
                        output bit ok);
        logic [7:0] d;
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            rd(a, d);
            if (((d & mask) != 0) == want) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit ok;
        int f0, n0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(2'd0, d); chk(d == 8'h00, "R1 ctrl", d, 0);
        rd(2'd1, d); chk(d == 8'h00, "R1 status", d, 0);
        rd(2'd2, d); chk(d == 8'h00, "R1 data", d, 0);
        chk(irq == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R1 pins",
            {irq, scl_oe, sda_oe}, 0);

        // R12 data write on a free bus
        f0 = falls;
        wr(2'd2, 8'hA5);
        repeat (60) @(negedge clk);
        chk(falls == f0, "R12 scl quiet", falls, f0);
        rd(2'd0, d); chk(d[2] == 1'b0, "R12 bus free", d[2], 0);

        // R3 start refused without master or transmit
        wr(2'd0, 8'hC4);
        repeat (40) @(negedge clk);
        rd(2'd0, d); chk(d[2] == 1'b0 && starts == 0, "R3 no master-tx", starts, 0);
        wr(2'd0, 8'hA4);
        repeat (40) @(negedge clk);
        rd(2'd0, d); chk(d[2] == 1'b0 && starts == 0, "R3 no master", starts, 0);

        // R2 start
        wr(2'd0, 8'hF4);
        poll(2'd1, 8'h40, 1'b1, ok);
        chk(ok, "R2 start flag", ok, 1);
        repeat (2) @(negedge clk);
        chk(starts == 1, "R2 sda fell with scl high", starts, 1);
        rd(2'd1, d); chk(d == 8'hC0, "R2 status", d, 8'hC0);
        rd(2'd0, d); chk(d == 8'hF4, "R2 ctrl busy", d, 8'hF4);
        chk(irq == 1'b1, "R7 irq after start", irq, 1);

        // R9 flag write semantics
        wr(2'd1, 8'hC1);
        rd(2'd1, d); chk(d == 8'hC0, "R9 write 1 keeps", d, 8'hC0);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk(d == 8'h00, "R9 write 0 clears", d, 0);

        // R4 R6 R7 R8 every byte value
        for (int b = 0; b < 256; b++) begin
            ack_mode = ((b % 5) == 3);
            n0 = frames;
            wr(2'd2, 8'(b));
            poll(2'd1, 8'h80, 1'b1, ok);
            chk(ok, "R7 frame flag", ok, 1);
            chk(scl_line == 1'b1, "R7 flag during ninth high", scl_line, 1);
            chk(irq == 1'b1, "R7 irq", irq, 1);
            repeat (PH*4 + 8) @(negedge clk);
            chk(frames == n0 + 1, "R4 nine pulses", frames, n0 + 1);
            chk(mbyte == 8'(b), "R4 byte MSB first", mbyte, b);
            rd(2'd1, d);
            chk(d[0] == ack_mode, "R6 ack bit", d[0], ack_mode);
            chk(scl_line == 1'b0, "R8 scl parked", scl_line, 0);
            if (b < 3) begin
                f0 = falls;
                repeat (80) @(negedge clk);
                chk(falls == f0 && scl_line == 1'b0, "R8 held low", falls, f0);
            end
            if (b == 3) begin
                wr(2'd0, 8'hE5);
                rd(2'd1, d); chk(d[0] == 1'b0, "R10 ack cleared", d[0], 0);
                rd(2'd0, d); chk(d[2] == 1'b1, "R10 bus kept", d[2], 1);
            end
            if (b == 255) begin
                wr(2'd0, 8'h65);
                rd(2'd1, d);
                chk(d[7] == 1'b1 && irq == 1'b0, "R7 irq masked", irq, 0);
            end
            wr(2'd1, 8'h00);
        end

        // R11 stop
        wr(2'd0, 8'h60);
        poll(2'd0, 8'h04, 1'b0, ok);
        chk(ok, "R11 busy cleared", ok, 1);
        repeat (2) @(negedge clk);
        chk(stops == 1, "R11 sda rose with scl high", stops, 1);
        chk(scl_line && sda_line, "R11 lines released", {scl_line, sda_line}, 3);

        // R12 after stop
        f0 = falls;
        wr(2'd2, 8'h3C);
        repeat (60) @(negedge clk);
        chk(falls == f0 && scl_oe == 1'b0, "R12 quiet after stop", falls, f0);

        // R5 phase length
        chk(min_run >= PH, "R5 min phase", min_run, PH);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule